// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a core from one operating point to another. An operating point is a pair: a core-to-bus clock ratio and an 8-bit voltage identification (VID) code. Software loads a new target with a single write strobe. The sequencer then walks the VID output toward the target one code at a time, waiting a programmable settle time after each code. It updates the ratio output in one jump. The order of the two phases depends on the direction of the change. When the frequency rises, the voltage goes up first and the ratio follows. When the frequency falls, the ratio drops first and the voltage comes down afterwards.

The clock synthesizer and the voltage regulator sit outside the block. The regulator's timing is modelled by the settle count. The synthesizer's timing is modelled by a lock-acknowledge input, which the sequencer waits for after every ratio change. The bus clock is not touched. The outputs `ratio_out`, `vid_out`, `busy` and `drop_flag` together form the status view. A target VID is first limited to a programmed window. A write that arrives while a transition is running is discarded and noted in a sticky flag.

Top module: `vf_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ratio_out` loads `rst_ratio`, `vid_out` loads `rst_vid`, and `busy` and `drop_flag` clear.
- R2: A `tgt_wr` pulse while `busy` is 0 is accepted, and `busy` reads 1 on the following cycle. While `busy` is 0, neither `ratio_out` nor `vid_out` changes, and every output change happens with `busy` at 1.
- R3: When the target ratio is larger than `ratio_out`, all VID steps complete before `ratio_out` changes, and the ratio changes while `vid_out` is stable.
- R4: When the target ratio is smaller than `ratio_out`, `ratio_out` changes before the first VID step.
- R5: Every change of `vid_out` is exactly +1 or -1 code. A larger code means a higher voltage.
- R6: Two consecutive changes of `vid_out` are at least `settle_cyc`+1 clock cycles apart.
- R7: After `ratio_out` changes, `vid_out` holds and `busy` stays 1 until `lock_ack` is seen high. A `lock_ack` outside this wait has no effect.
- R8: A target with the same ratio but a different VID performs only VID steps, and `ratio_out` never changes.
- R9: A target equal to the current ratio and the clamped VID completes at once: `busy` stays 0 and no output changes.
- R10: A `tgt_wr` while `busy` is 1 is ignored and sets `drop_flag`. `drop_flag` stays set until a `drop_clr` pulse; a new drop in the same cycle wins.
- R11: The target VID is clamped into [`vid_min`, `vid_max`] when the write is accepted, so the final `vid_out` is the clamped value.
- R12: `ratio_out` changes exactly once per transition, and it goes straight to the target value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_ratio | input | RATIO_W | Ratio loaded at reset |
| rst_vid | input | VID_W | VID code loaded at reset |
| vid_min | input | VID_W | Lowest allowed target VID |
| vid_max | input | VID_W | Highest allowed target VID |
| settle_cyc | input | CNT_W | Settle wait after each VID step, in cycles |
| tgt_wr | input | 1 | Write strobe for a new target |
| tgt_ratio | input | RATIO_W | Target core-to-bus ratio |
| tgt_vid | input | VID_W | Target VID code, before clamping |
| drop_clr | input | 1 | Clears the dropped-request flag |
| lock_ack | input | 1 | Synthesizer lock acknowledge |
| ratio_out | output | RATIO_W | Current core-to-bus ratio |
| vid_out | output | VID_W | Current VID code to the regulator |
| busy | output | 1 | Transition in progress |
| drop_flag | output | 1 | Sticky flag: a write was ignored while busy |

## Verification
The bound checker watches several rules on every cycle:
- every VID move is a single code, and consecutive VID moves respect the settle spacing;
- the outputs do not move while the block is idle, and every output change happens while `busy` is 1;
- a rising ratio never coincides with a VID move, and the cycle after a ratio change holds the VID;
- the dropped flag stays set until it is cleared.

Only the directed scenarios can show the rules that depend on the target the block latched:
- the phase order for each direction, measured against the cycle of the lock acknowledge;
- the ratio-only-once rule and the voltage-only case;
- the immediate no-op completion;
- clamping into the programmed window;
- the fact that an ignored write leaves the final operating point untouched.

// File: rtl/vf_pkg.sv
package vf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_VSTEP = 3'd1,
        ST_VWAIT = 3'd2,
        ST_RSET  = 3'd3,
        ST_RLOCK = 3'd4
    } vf_state_e;

endpackage

// File: rtl/vf_clamp.sv
module vf_clamp #(
    parameter int VID_W = 8
) (
    input  logic [VID_W-1:0] vin,
    input  logic [VID_W-1:0] lo,
    input  logic [VID_W-1:0] hi,
    output logic [VID_W-1:0] vout
);
    always_comb begin
        if (vin < lo) begin
            vout = lo;
        end else if (vin > hi) begin
            vout = hi;
        end else begin
            vout = vin;
        end
    end
endmodule

// File: rtl/vf_vid_step.sv
module vf_vid_step #(
    parameter int VID_W = 8
) (
    input  logic [VID_W-1:0] cur,
    input  logic [VID_W-1:0] tgt,
    output logic [VID_W-1:0] nxt,
    output logic             at_tgt
);
    localparam logic [VID_W-1:0] ONE = VID_W'(1);

    always_comb begin
        at_tgt = (cur == tgt);
        if (cur < tgt) begin
            nxt = cur + ONE;
        end else if (cur > tgt) begin
            nxt = cur - ONE;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/vf_settle_tmr.sv
module vf_settle_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = count;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/vf_seq.sv
module vf_seq
    import vf_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] rst_ratio,
    input  logic [VID_W-1:0]   rst_vid,
    input  logic [VID_W-1:0]   vid_min,
    input  logic [VID_W-1:0]   vid_max,
    input  logic [CNT_W-1:0]   settle_cyc,
    input  logic               tgt_wr,
    input  logic [RATIO_W-1:0] tgt_ratio,
    input  logic [VID_W-1:0]   tgt_vid,
    input  logic               drop_clr,
    input  logic               lock_ack,
    output logic [RATIO_W-1:0] ratio_out,
    output logic [VID_W-1:0]   vid_out,
    output logic               busy,
    output logic               drop_flag
);

    typedef struct packed {
        vf_state_e          st;
        logic               rat_pend;
        logic               volt_pend;
        logic               drop;
        logic [RATIO_W-1:0] ratio;
        logic [VID_W-1:0]   vid;
        logic [RATIO_W-1:0] t_ratio;
        logic [VID_W-1:0]   t_vid;
    } seq_t;

    seq_t s_d, s_q;

    logic [VID_W-1:0] clamped_vid;
    logic [VID_W-1:0] vid_nxt;
    logic             vid_at;
    logic             tmr_load;
    logic             tmr_done;
    logic             is_busy;
    logic             same_ratio;
    logic             same_vid;

    vf_clamp #(.VID_W(VID_W)) u_clamp (
        .vin  (tgt_vid),
        .lo   (vid_min),
        .hi   (vid_max),
        .vout (clamped_vid)
    );

    vf_vid_step #(.VID_W(VID_W)) u_step (
        .cur    (s_q.vid),
        .tgt    (s_q.t_vid),
        .nxt    (vid_nxt),
        .at_tgt (vid_at)
    );

    vf_settle_tmr #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .count   (settle_cyc),
        .expired (tmr_done)
    );

    always_comb begin
        s_d        = s_q;
        tmr_load   = 1'b0;
        is_busy    = (s_q.st != ST_IDLE);
        same_ratio = (tgt_ratio == s_q.ratio);
        same_vid   = (clamped_vid == s_q.vid);

        // Dropped-request flag: a new drop has priority over a clear.
        if (tgt_wr && is_busy) begin
            s_d.drop = 1'b1;
        end else if (drop_clr) begin
            s_d.drop = 1'b0;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (tgt_wr) begin
                    s_d.t_ratio   = tgt_ratio;
                    s_d.t_vid     = clamped_vid;
                    s_d.rat_pend  = 1'b0;
                    s_d.volt_pend = 1'b0;
                    if (same_ratio && same_vid) begin
                        s_d.st = ST_IDLE;
                    end else if (same_ratio) begin
                        s_d.st = ST_VSTEP;
                    end else if (tgt_ratio > s_q.ratio) begin
                        s_d.st       = ST_VSTEP;
                        s_d.rat_pend = 1'b1;
                    end else begin
                        s_d.st        = ST_RSET;
                        s_d.volt_pend = 1'b1;
                    end
                end
            end
            ST_VSTEP: begin
                if (vid_at) begin
                    if (s_q.rat_pend) begin
                        s_d.st       = ST_RSET;
                        s_d.rat_pend = 1'b0;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end else begin
                    s_d.vid  = vid_nxt;
                    tmr_load = 1'b1;
                    s_d.st   = ST_VWAIT;
                end
            end
            ST_VWAIT: begin
                if (tmr_done) begin
                    s_d.st = ST_VSTEP;
                end
            end
            ST_RSET: begin
                s_d.ratio = s_q.t_ratio;
                s_d.st    = ST_RLOCK;
            end
            ST_RLOCK: begin
                if (lock_ack) begin
                    if (s_q.volt_pend) begin
                        s_d.st        = ST_VSTEP;
                        s_d.volt_pend = 1'b0;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st        <= ST_IDLE;
            s_q.rat_pend  <= 1'b0;
            s_q.volt_pend <= 1'b0;
            s_q.drop      <= 1'b0;
            s_q.ratio     <= rst_ratio;
            s_q.vid       <= rst_vid;
            s_q.t_ratio   <= rst_ratio;
            s_q.t_vid     <= rst_vid;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio_out = s_q.ratio;
    assign vid_out   = s_q.vid;
    assign busy      = (s_q.st != ST_IDLE);
    assign drop_flag = s_q.drop;

endmodule

// File: rtl/vf_seq_chk.sv
module vf_seq_chk #(
    parameter int RATIO_W = 6,
    parameter int VID_W   = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VID_W-1:0]   rst_vid,
    input logic [CNT_W-1:0]   settle_cyc,
    input logic               drop_clr,
    input logic [RATIO_W-1:0] ratio_out,
    input logic [VID_W-1:0]   vid_out,
    input logic               busy,
    input logic               drop_flag
);
    localparam int SW = CNT_W + 1;

    logic [VID_W-1:0] prev_vid_q;
    logic [SW-1:0]    since_q;
    logic             seen_q;

    // Counts the cycles since the last VID move, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vid_q <= rst_vid;
            since_q    <= '0;
            seen_q     <= 1'b0;
        end else begin
            prev_vid_q <= vid_out;
            if (vid_out != prev_vid_q) begin
                since_q <= '0;
                seen_q  <= 1'b1;
            end else if (since_q != {SW{1'b1}}) begin
                since_q <= since_q + SW'(1);
            end
        end
    end

    p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (vid_out != prev_vid_q)) |-> (since_q >= ({1'b0, settle_cyc} + SW'(1))));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vid_out) |-> ((vid_out == $past(vid_out) + VID_W'(1)) ||
                              (vid_out == $past(vid_out) - VID_W'(1))));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(vid_out) && $stable(ratio_out)));

    p_change_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vid_out) || !$stable(ratio_out)) |-> busy);

    p_up_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_out > $past(ratio_out)) |-> $stable(vid_out));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_out) |=> ($stable(vid_out) && busy));

    p_drop_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && !drop_clr) |=> drop_flag);

endmodule

bind vf_seq vf_seq_chk #(
    .RATIO_W (RATIO_W),
    .VID_W   (VID_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_vid    (rst_vid),
    .settle_cyc (settle_cyc),
    .drop_clr   (drop_clr),
    .ratio_out  (ratio_out),
    .vid_out    (vid_out),
    .busy       (busy),
    .drop_flag  (drop_flag)
);

// File: tb/vf_seq_tb.sv
module vf_seq_tb;

    localparam int RATIO_W = 6;
    localparam int VID_W   = 8;
    localparam int CNT_W   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [RATIO_W-1:0] rst_ratio = 6'd10;
    logic [VID_W-1:0]   rst_vid = 8'd100;
    logic [VID_W-1:0]   vid_min = 8'd0;
    logic [VID_W-1:0]   vid_max = 8'd255;
    logic [CNT_W-1:0]   settle_cyc = 16'd3;
    logic               tgt_wr = 1'b0;
    logic [RATIO_W-1:0] tgt_ratio = '0;
    logic [VID_W-1:0]   tgt_vid = '0;
    logic               drop_clr = 1'b0;
    logic               lock_ack = 1'b0;
    logic [RATIO_W-1:0] ratio_out;
    logic [VID_W-1:0]   vid_out;
    logic               busy;
    logic               drop_flag;

    always #2 clk = ~clk;

    vf_seq #(.RATIO_W(RATIO_W), .VID_W(VID_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_ratio(rst_ratio), .rst_vid(rst_vid),
        .vid_min(vid_min), .vid_max(vid_max), .settle_cyc(settle_cyc),
        .tgt_wr(tgt_wr), .tgt_ratio(tgt_ratio), .tgt_vid(tgt_vid),
        .drop_clr(drop_clr), .lock_ack(lock_ack), .ratio_out(ratio_out),
        .vid_out(vid_out), .busy(busy), .drop_flag(drop_flag)
    );

    int total = 0;
    int bad   = 0;

    // Monitor and synthesizer model, both on the falling edge.
    int cyc = 0;
    int m_vid = 100;
    int m_ratio = 10;
    int vid_changes, ratio_changes, first_vid, last_vid, ratio_cyc, min_gap, bad_step;
    int ack_cyc;
    bit busy_seen;
    int lock_dly = 3;
    int lk_cnt = 0;

    task automatic clear_log();
        @(posedge clk);
        vid_changes = 0; ratio_changes = 0; first_vid = -1; last_vid = -1;
        ratio_cyc = -1; min_gap = 1000000; bad_step = 0; ack_cyc = -1; busy_seen = 0;
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        lock_ack = 1'b0;
        if (rst_n) begin
            if (busy) busy_seen = 1;
            if (int'(vid_out) != m_vid) begin
                if (vid_changes > 0 && (cyc - last_vid) < min_gap) min_gap = cyc - last_vid;
                if (int'(vid_out) - m_vid != 1 && m_vid - int'(vid_out) != 1) bad_step = bad_step + 1;
                if (vid_changes == 0) first_vid = cyc;
                last_vid = cyc;
                vid_changes = vid_changes + 1;
                m_vid = int'(vid_out);
            end
            if (int'(ratio_out) != m_ratio) begin
                ratio_cyc = cyc;
                ratio_changes = ratio_changes + 1;
                m_ratio = int'(ratio_out);
                lk_cnt = lock_dly;
            end else if (lk_cnt > 0) begin
                lk_cnt = lk_cnt - 1;
                if (lk_cnt == 0) begin
                    lock_ack = 1'b1;
                    ack_cyc = cyc;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_tgt(input int r, input int v);
        @(negedge clk);
        tgt_ratio = RATIO_W'(r);
        tgt_vid   = VID_W'(v);
        tgt_wr    = 1'b1;
        @(negedge clk);
        tgt_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        bit done = 0;
        for (int i = 0; i < 5000 && !done; i++) begin
            @(negedge clk);
            if (!busy) done = 1;
        end
        chk(done, "wait_idle timeout", int'(busy), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ratio_out == 6'd10, "R1 ratio", int'(ratio_out), 10);
        chk(vid_out == 8'd100, "R1 vid", int'(vid_out), 100);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(drop_flag == 1'b0, "R1 drop", int'(drop_flag), 0);
    endtask

    task automatic t_raise();
        clear_log();
        lock_dly = 3;
        write_tgt(14, 104);
        chk(busy == 1'b1, "R2 busy after write", int'(busy), 1);
        wait_idle();
        chk(ratio_out == 6'd14, "R12 final ratio", int'(ratio_out), 14);
        chk(vid_out == 8'd104, "R3 final vid", int'(vid_out), 104);
        chk(vid_changes == 4, "R5 step count", vid_changes, 4);
        chk(bad_step == 0, "R5 single code", bad_step, 0);
        chk(ratio_changes == 1, "R12 ratio once", ratio_changes, 1);
        chk(last_vid < ratio_cyc, "R3 volt before ratio", last_vid, ratio_cyc);
        chk(min_gap >= 4, "R6 settle gap", min_gap, 4);
    endtask

    task automatic t_lower();
        clear_log();
        lock_dly = 6;
        write_tgt(8, 98);
        wait_idle();
        chk(ratio_out == 6'd8, "R4 final ratio", int'(ratio_out), 8);
        chk(vid_out == 8'd98, "R4 final vid", int'(vid_out), 98);
        chk(ratio_cyc < first_vid, "R4 ratio before volt", ratio_cyc, first_vid);
        chk(first_vid > ack_cyc && ack_cyc > 0, "R7 volt waits lock", first_vid, ack_cyc + 2);
        chk(ratio_changes == 1, "R12 ratio once down", ratio_changes, 1);
    endtask

    task automatic t_volt_only();
        clear_log();
        settle_cyc = 16'd0;
        write_tgt(8, 101);
        wait_idle();
        chk(ratio_changes == 0, "R8 ratio untouched", ratio_changes, 0);
        chk(vid_changes == 3, "R8 volt steps", vid_changes, 3);
        chk(vid_out == 8'd101, "R8 final vid", int'(vid_out), 101);
        chk(min_gap >= 1, "R6 settle zero gap", min_gap, 1);
        settle_cyc = 16'd3;
    endtask

    task automatic t_noop();
        clear_log();
        write_tgt(8, 101);
        repeat (10) @(negedge clk);
        chk(!busy_seen, "R9 no busy", int'(busy_seen), 0);
        chk(vid_changes == 0 && ratio_changes == 0, "R9 no change",
            vid_changes + ratio_changes, 0);
    endtask

    task automatic t_drop();
        clear_log();
        write_tgt(12, 103);
        repeat (2) @(negedge clk);
        chk(busy == 1'b1, "R10 busy before second write", int'(busy), 1);
        write_tgt(5, 50);
        wait_idle();
        chk(ratio_out == 6'd12, "R10 ratio kept", int'(ratio_out), 12);
        chk(vid_out == 8'd103, "R10 vid kept", int'(vid_out), 103);
        chk(drop_flag == 1'b1, "R10 drop set", int'(drop_flag), 1);
        repeat (3) @(negedge clk);
        chk(drop_flag == 1'b1, "R10 drop sticky", int'(drop_flag), 1);
        drop_clr = 1'b1;
        @(negedge clk);
        drop_clr = 1'b0;
        chk(drop_flag == 1'b0, "R10 drop cleared", int'(drop_flag), 0);
    endtask

    task automatic t_clamp();
        clear_log();
        vid_min = 8'd90;
        vid_max = 8'd110;
        settle_cyc = 16'd1;
        write_tgt(12, 200);
        wait_idle();
        chk(vid_out == 8'd110, "R11 clamp high", int'(vid_out), 110);
        write_tgt(12, 10);
        wait_idle();
        chk(vid_out == 8'd90, "R11 clamp low", int'(vid_out), 90);
        chk(ratio_out == 6'd12, "R8 clamp ratio kept", int'(ratio_out), 12);
    endtask

    task automatic t_stray_ack();
        clear_log();
        write_tgt(12, 92);
        @(negedge clk);
        lock_ack = 1'b1;
        wait_idle();
        chk(vid_out == 8'd92 && ratio_out == 6'd12, "R7 stray ack harmless",
            int'(vid_out), 92);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raise();
        t_lower();
        t_volt_only();
        t_noop();
        t_drop();
        t_clamp();
        t_stray_ack();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule